// File: doc/BRIEF.md
# LVDS ADC Sample Deserializer

This block turns the serial output of a high-speed ADC back into 16-bit samples. The link is source-synchronous. Every data lane and the frame lane are sampled on both edges of the bit clock `clk`, so each clock cycle delivers two serial bits per lane. Two lane layouts are supported, and the choice is held stable while the block is in reset. In quad mode, four lanes each carry four bits of a sample, so one sample arrives every two clock cycles. In double mode, eight lanes each carry two bits, so one sample arrives every cycle. The slower divided clock of a real receiver is represented by a one-cycle sample strobe inside the `clk` domain.

The frame lane is deserialized exactly like a data lane. An alignment controller compares the captured frame pattern with the expected one. When the pattern is wrong, it moves the word boundary by one bit and then waits a guard period before it looks again. It declares lock after a run of correct patterns. An external bitslip request moves the boundary by hand. A test source can replace the ADC data with a 16-bit counter. ADC samples can optionally be converted from offset binary to two's complement.

Top module: `adc_lvds_deser`

## Requirements
- R1: During and straight after synchronous reset, `sample_o` is 0 and `valid_o`, `locked_o` and `slip_o` are low.
- R2: In quad mode (`dbl_mode_i`=0), lane k (0..3) carries sample bits 12+k, 8+k, 4+k, k in that serial order, with the first bit first. Once locked, `sample_o` reproduces the transmitted samples in order, without loss or repetition.
- R3: In double mode (`dbl_mode_i`=1), lane j (0..7) carries sample bits 2j+1 then 2j. Once locked, `sample_o` reproduces the transmitted samples in order.
- R4: The word counts as aligned when the frame lane window reads 1100 in quad mode or 10 in double mode, first serial bit leftmost. The frame lane is high for the first half of each sample. Alignment is reached from any initial bit skew of the stream.
- R5: An automatic bitslip is a single-cycle pulse on `slip_o`. After any slip, no automatic slip follows for at least 8 sample periods, and `slip_o` is never high while `locked_o` is high.
- R6: `locked_o` rises after 16 consecutive aligned frame comparisons and stays high while the frame remains aligned.
- R7: `valid_o` pulses once per sample: every second cycle in quad mode and every cycle in double mode.
- R8: `valid_o` stays low while the block is unlocked, unless `test_en_i` is high.
- R9: With `test_en_i` high, `sample_o` carries a counter that starts at 0 after reset, rises by 1 per sample and wraps from 65535 to 0.
- R10: With `ob_to_tc_i` high, bit 15 of every ADC sample is inverted and all other bits pass unchanged. The test counter is never converted.
- R11: A rising edge on `bitslip_i` moves the word boundary by one bit and drops `locked_o`. The controller then realigns and locks again, and the data is correct afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; lanes are sampled on both edges |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_i | input | 8 | Serial data lanes (lanes 0..3 used in quad mode) |
| frame_i | input | 1 | Serial frame lane |
| dbl_mode_i | input | 1 | 0 = quad layout, 1 = double layout |
| test_en_i | input | 1 | Selects the test counter as the output source |
| ob_to_tc_i | input | 1 | Inverts bit 15 of ADC samples |
| bitslip_i | input | 1 | Manual boundary shift, acting on its rising edge |
| sample_o | output | 16 | Rebuilt sample |
| valid_o | output | 1 | One pulse per delivered sample |
| locked_o | output | 1 | Frame alignment achieved |
| slip_o | output | 1 | Pulse on each automatic bitslip |

## Verification
On every cycle, the assertions check the valid gating against lock and test mode, the alternating valid cadence in quad mode, the minimum spacing between automatic slips, and that no slip happens while locked. Other behaviours can only be shown by the bench's scenarios. These are the bit mapping of both lane layouts, convergence from each initial skew, the lock count, recovery after a manual slip, the format inversion, and the counter wrap. For each of these the bench drives a stream of known samples and compares the output sequence.

// File: rtl/adc_deser_pkg.sv
// Shared geometry of the deserializer: lane counts, bits per lane per
// sample, and the width of the per-lane bit history.
package adc_deser_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int NUM_LANES  = 8;
    localparam int QUAD_LANES = 4;
    localparam int QUAD_BITS  = SAMPLE_W / QUAD_LANES;   // 4
    localparam int DBL_BITS   = SAMPLE_W / NUM_LANES;    // 2
    localparam int HIST_W     = 2 * QUAD_BITS;           // room for every offset
    localparam int OFF_W      = $clog2(QUAD_BITS);

    typedef logic [HIST_W-1:0] hist_t;
    typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/adc_lane_capture.sv
// Dual-edge capture of one serial lane. Assumes the lane is stable around
// both clock edges. Each rising edge shifts two bits into the history: the
// bit taken at the preceding falling edge (older), then the bit taken at
// this rising edge (newest, held at bit 0).
module adc_lane_capture
    import adc_deser_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din_i,
    output hist_t hist_o
);
    logic fall_q;

    // Capture the falling-edge bit.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= din_i;
    end

    // Shift the bit pair into the history, oldest bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_o <= '0;
        else        hist_o <= {hist_o[HIST_W-3:0], fall_q, din_i};
    end
endmodule

// File: rtl/adc_word_assembler.sv
// Picks the sample window out of each lane history at the current bit
// offset, and scatters the window bits into sample positions according to
// the lane layout. Purely combinational.
module adc_word_assembler
    import adc_deser_pkg::*;
(
    input  logic [NUM_LANES-1:0][HIST_W-1:0] lane_hist_i,
    input  off_t                              off_i,
    input  logic                              dbl_mode_i,
    output logic [SAMPLE_W-1:0]               word_o
);
    // Window extraction and bit scatter for the selected layout.
    always_comb begin
        logic [HIST_W-1:0] win;
        word_o = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            win = lane_hist_i[l] >> off_i;
            if (dbl_mode_i) begin
                for (int m = 0; m < DBL_BITS; m++)
                    word_o[DBL_BITS*l + m] = win[m];
            end else if (l < QUAD_LANES) begin
                for (int m = 0; m < QUAD_BITS; m++)
                    word_o[QUAD_LANES*m + l] = win[m];
            end
        end
    end
endmodule

// File: rtl/adc_frame_aligner.sv
// Frame alignment controller. Once per sample strobe it compares the frame
// window with the expected pattern. On a mismatch it advances the bit
// offset by one, pulses slip_o, and waits GUARD_TICKS strobes before
// comparing again. LOCK_TICKS consecutive matches set locked_o. A rising
// edge on bitslip_i is held pending until the next strobe, where it forces
// a slip without pulsing slip_o. Assumes dbl_mode_i changes only in reset.
module adc_frame_aligner
    import adc_deser_pkg::*;
#(
    parameter int GUARD_TICKS = 8,
    parameter int LOCK_TICKS  = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  dbl_mode_i,
    input  hist_t frame_hist_i,
    input  logic  bitslip_i,
    output off_t  off_o,
    output logic  locked_o,
    output logic  slip_o
);
    localparam int GUARD_W = $clog2(GUARD_TICKS + 1);
    localparam int LOCK_W  = $clog2(LOCK_TICKS + 1);

    logic [GUARD_W-1:0] guard_q;
    logic [LOCK_W-1:0]  good_q;
    logic               bs_q, pend_q;
    logic               frame_ok, man_edge;
    off_t               off_next;
    hist_t              fwin;

    // Frame pattern check and next bit offset (wraps per layout).
    always_comb begin
        fwin     = frame_hist_i >> off_o;
        frame_ok = dbl_mode_i ? (fwin[1:0] == 2'b10) : (fwin[3:0] == 4'b1100);
        off_next = dbl_mode_i ? {{(OFF_W-1){1'b0}}, ~off_o[0]} : off_o + 1'b1;
        man_edge = bitslip_i & ~bs_q;
    end

    // Slip, guard and lock sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_o    <= '0;
            guard_q  <= '0;
            good_q   <= '0;
            locked_o <= 1'b0;
            slip_o   <= 1'b0;
            bs_q     <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            bs_q   <= bitslip_i;
            slip_o <= 1'b0;
            if (tick_i) begin
                if (pend_q || man_edge) begin
                    off_o    <= off_next;
                    guard_q  <= GUARD_W'(GUARD_TICKS);
                    good_q   <= '0;
                    locked_o <= 1'b0;
                    pend_q   <= 1'b0;
                end else if (guard_q != '0) begin
                    guard_q <= guard_q - 1'b1;
                end else if (frame_ok) begin
                    if (!locked_o) begin
                        if (good_q == LOCK_W'(LOCK_TICKS - 1)) locked_o <= 1'b1;
                        good_q <= good_q + 1'b1;
                    end
                end else begin
                    off_o    <= off_next;
                    guard_q  <= GUARD_W'(GUARD_TICKS);
                    good_q   <= '0;
                    locked_o <= 1'b0;
                    slip_o   <= 1'b1;
                end
            end else if (man_edge) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_lvds_deser.sv
// Top level: nine dual-edge lane captures (eight data lanes and the frame),
// a frame aligner, a word assembler, a test counter and the output register.
// The sample strobe fires every cycle in double mode and every other cycle
// in quad mode. Assumes the mode input is changed only during reset.
module adc_lvds_deser
    import adc_deser_pkg::*;
#(
    parameter int GUARD_TICKS = 8,
    parameter int LOCK_TICKS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LANES-1:0] lane_i,
    input  logic                frame_i,
    input  logic                dbl_mode_i,
    input  logic                test_en_i,
    input  logic                ob_to_tc_i,
    input  logic                bitslip_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o,
    output logic                locked_o,
    output logic                slip_o
);
    logic [NUM_LANES-1:0][HIST_W-1:0] lane_hist;
    hist_t                            frame_hist;
    off_t                             off;
    logic [SAMPLE_W-1:0]              word, test_cnt;
    logic                             phase_q, tick;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        adc_lane_capture u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (lane_i[g]),
            .hist_o (lane_hist[g])
        );
    end

    adc_lane_capture u_frame_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (frame_i),
        .hist_o (frame_hist)
    );

    adc_frame_aligner #(
        .GUARD_TICKS (GUARD_TICKS),
        .LOCK_TICKS  (LOCK_TICKS)
    ) u_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .dbl_mode_i   (dbl_mode_i),
        .frame_hist_i (frame_hist),
        .bitslip_i    (bitslip_i),
        .off_o        (off),
        .locked_o     (locked_o),
        .slip_o       (slip_o)
    );

    adc_word_assembler u_asm (
        .lane_hist_i (lane_hist),
        .off_i       (off),
        .dbl_mode_i  (dbl_mode_i),
        .word_o      (word)
    );

    // Sample strobe: every cycle in double mode, alternate cycles in quad.
    assign tick = dbl_mode_i | phase_q;

    // Phase toggle that divides the bit clock for quad mode.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= dbl_mode_i ? 1'b0 : ~phase_q;
    end

    // Test counter, advanced once per delivered test sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                test_cnt <= '0;
        else if (tick && test_en_i) test_cnt <= test_cnt + 1'b1;
    end

    // Output register: source select, format conversion, valid gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= tick & (locked_o | test_en_i);
            if (tick)
                sample_o <= test_en_i ? test_cnt
                                      : (word ^ {ob_to_tc_i, {(SAMPLE_W-1){1'b0}}});
        end
    end
endmodule

// File: rtl/adc_deser_chk.sv
// Cycle-level properties of the deserializer, attached by bind.
module adc_deser_chk #(
    parameter int GUARD_TICKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic dbl_mode_i,
    input logic test_en_i,
    input logic valid_o,
    input logic locked_o,
    input logic slip_o
);
    logic [7:0] since_slip;

    // Cycles since the last automatic slip, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_slip <= 8'hFF;
        else if (slip_o)        since_slip <= 8'd0;
        else if (since_slip != 8'hFF) since_slip <= since_slip + 8'd1;
    end

    // R8
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(locked_o) || $past(test_en_i)));

    // R7
    quad_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_mode_i && valid_o) |=> !valid_o);

    // R5
    slip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> (since_slip >= 8'(GUARD_TICKS)));

    // R5
    slip_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> !locked_o);
endmodule

bind adc_lvds_deser adc_deser_chk #(.GUARD_TICKS(GUARD_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl_mode_i (dbl_mode_i),
    .test_en_i  (test_en_i),
    .valid_o    (valid_o),
    .locked_o   (locked_o),
    .slip_o     (slip_o)
);

// File: tb/adc_lvds_deser_bench.sv
module adc_lvds_deser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lane_i = '0;
    logic        frame_i = 1'b0;
    logic        dbl_mode_i = 1'b0;
    logic        test_en_i = 1'b0;
    logic        ob_to_tc_i = 1'b0;
    logic        bitslip_i = 1'b0;
    logic [15:0] sample_o;
    logic        valid_o, locked_o, slip_o;

    int  n_checks = 0;
    int  n_errors = 0;
    int  t_idx = 0;
    int  cur_skew = 0;
    bit  frame_stuck = 1'b0;
    bit  done = 1'b0;
    int  cyc_total = 0;
    logic [6:0] up [512];

    always #2.5 clk = ~clk;   // 200 MHz

    adc_lvds_deser u_adc_lvds_deser (
        .clk(clk), .rst_n(rst_n), .lane_i(lane_i), .frame_i(frame_i),
        .dbl_mode_i(dbl_mode_i), .test_en_i(test_en_i), .ob_to_tc_i(ob_to_tc_i),
        .bitslip_i(bitslip_i), .sample_o(sample_o), .valid_o(valid_o),
        .locked_o(locked_o), .slip_o(slip_o)
    );

    always @(posedge clk) cyc_total <= cyc_total + 1;

    function automatic logic [15:0] smp(int i);
        return {up[i % 512], 9'(i % 512)};
    endfunction

    // Serialize the bench sample stream at serial index t_idx.
    task automatic drive_bits();
        int w, u, i, b;
        logic [15:0] s;
        logic [7:0]  l;
        w = dbl_mode_i ? 2 : 4;
        u = t_idx - cur_skew;
        l = '0;
        if (u < 0) begin
            lane_i  = '0;
            frame_i = 1'b0;
        end else begin
            i = u / w;
            b = u % w;
            s = smp(i);
            for (int k = 0; k < 8; k++) begin
                if (dbl_mode_i)  l[k] = s[2*k + 1 - b];        // R3
                else if (k < 4)  l[k] = s[12 + k - 4*b];       // R2
            end
            lane_i  = l;
            frame_i = frame_stuck ? 1'b0 : (b < w/2);          // R4
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1.25; drive_bits(); t_idx = t_idx + 1;
            #2.5;  drive_bits(); t_idx = t_idx + 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic apply_reset(bit dbl, int skew, bit fmt, bit tst, bit stuck);
        @(negedge clk);
        rst_n = 1'b0;
        dbl_mode_i = dbl; cur_skew = skew; ob_to_tc_i = fmt;
        test_en_i = tst; frame_stuck = stuck; bitslip_i = 1'b0;
        repeat (4) @(negedge clk);
        t_idx = 0;
        rst_n = 1'b1;
    endtask

    // Wait for lock while watching slip spacing.
    task automatic wait_lock(bit dbl, string tag);
        int n, last, min_gap, bad_lock;
        n = 0; last = -1; min_gap = 1000; bad_lock = 0;
        while (!locked_o && n < 4000) begin
            @(negedge clk); n++;
            if (slip_o) begin
                if (locked_o) bad_lock++;
                if (last >= 0 && n - last < min_gap) min_gap = n - last;
                last = n;
            end
        end
        check(locked_o == 1'b1, "R6", {tag, " lock reached"}, locked_o, 1);
        check(min_gap >= 8 * (dbl ? 1 : 2), "R5", {tag, " slip spacing"}, min_gap, 8 * (dbl ? 1 : 2));
        check(bad_lock == 0, "R5", {tag, " slip while locked"}, bad_lock, 0);
    endtask

    // Collect n valid samples and compare them with the stream.
    task automatic collect(bit dbl, bit fmt, int n, string req, string tag);
        int cnt, cyc, last, gapbad, bad, idx, fa, fe, tl;
        logic [15:0] exp;
        cnt = 0; cyc = 0; last = -1; gapbad = 0; bad = 0; idx = 0; fa = 0; fe = 0;
        tl = dbl ? 1 : 2;
        while (cnt < n && cyc < 3000) begin
            @(negedge clk); cyc++;
            if (valid_o) begin
                if (last >= 0 && cyc - last != tl) gapbad++;
                last = cyc;
                idx = (cnt == 0) ? int'(sample_o[8:0]) : (idx + 1) % 512;
                exp = smp(idx) ^ {fmt, 15'd0};
                if (sample_o !== exp) begin
                    if (bad == 0) begin fa = sample_o; fe = exp; end
                    bad++;
                end
                cnt++;
            end
        end
        check(cnt == n, "R7", {tag, " sample count"}, cnt, n);
        check(gapbad == 0, "R7", {tag, " valid cadence"}, gapbad, 0);
        check(bad == 0, req, {tag, " sample stream"}, fa, fe);
        check(locked_o == 1'b1, "R6", {tag, " lock held"}, locked_o, 1);
    endtask

    task automatic run_adc(bit dbl, int skew, bit fmt, string req, string tag);
        apply_reset(dbl, skew, fmt, 1'b0, 1'b0);
        wait_lock(dbl, tag);
        collect(dbl, fmt, 40, req, tag);
    endtask

    initial begin
        int vcount, lk, bad, fa, fe, wrap_ok;
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) up[i] = 7'($urandom());

        // R1: reset state
        repeat (3) @(negedge clk);
        check(sample_o == 16'd0, "R1", "sample in reset", sample_o, 0);
        check(valid_o == 1'b0,  "R1", "valid in reset", valid_o, 0);
        check(locked_o == 1'b0, "R1", "locked in reset", locked_o, 0);
        check(slip_o == 1'b0,   "R1", "slip in reset", slip_o, 0);

        // R2 / R4: quad mode from several skews
        run_adc(1'b0, 0, 1'b0, "R2", "quad skew0");
        run_adc(1'b0, 1, 1'b0, "R2", "quad skew1");
        run_adc(1'b0, 2, 1'b0, "R4", "quad skew2");
        run_adc(1'b0, 3, 1'b0, "R4", "quad skew3");
        run_adc(1'b0, int'($urandom_range(15, 4)), 1'b0, "R4", "quad skew rnd");
        // R3: double mode
        run_adc(1'b1, 0, 1'b0, "R3", "dbl skew0");
        run_adc(1'b1, 1, 1'b0, "R3", "dbl skew1");
        run_adc(1'b1, int'($urandom_range(9, 2)), 1'b0, "R3", "dbl skew rnd");
        // R10: format conversion on ADC data
        run_adc(1'b0, 5, 1'b1, "R10", "quad fmt");
        run_adc(1'b1, 3, 1'b1, "R10", "dbl fmt");

        // R11: manual bitslip after lock
        run_adc(1'b0, 2, 1'b0, "R2", "quad pre-slip");
        @(negedge clk); bitslip_i = 1'b1;
        @(negedge clk); bitslip_i = 1'b0;
        lk = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!locked_o) lk = 0;
        end
        check(lk == 0, "R11", "lock dropped by manual slip", lk, 0);
        wait_lock(1'b0, "R11 relock");
        collect(1'b0, 1'b0, 40, "R11", "after manual slip");

        // R8: no lock, no test -> no valid
        apply_reset(1'b0, 0, 1'b0, 1'b0, 1'b1);
        vcount = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (valid_o) vcount++;
        end
        check(vcount == 0, "R8", "valid while unlocked", vcount, 0);
        check(locked_o == 1'b0, "R8", "locked with dead frame", locked_o, 0);

        // R9 / R10: test counter with wrap, format flag set, no lock
        apply_reset(1'b1, 0, 1'b1, 1'b1, 1'b1);
        vcount = 0; bad = 0; fa = 0; fe = 0; wrap_ok = 0;
        while (vcount < 65540 && cyc_total < 185000) begin
            @(negedge clk);
            if (valid_o) begin
                if (sample_o !== 16'(vcount)) begin
                    if (bad == 0) begin fa = sample_o; fe = vcount & 16'hFFFF; end
                    bad++;
                end
                if (vcount == 65536 && sample_o == 16'd0) wrap_ok = 1;
                vcount++;
            end
        end
        check(vcount == 65540, "R9", "test samples delivered", vcount, 65540);
        check(bad == 0, "R9", "counter sequence (R10 no conversion)", fa, fe);
        check(wrap_ok == 1, "R9", "wrap to zero", wrap_ok, 1);
        check(locked_o == 1'b0, "R8", "test valid without lock", locked_o, 0);

        finish_run();
    end

    initial begin
        wait (cyc_total > 195000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc_total, 195000);
            finish_run();
        end
    end
endmodule